// File: doc/BRIEF.md
# Floating-Point Control and Status Register Bank

This block keeps the floating-point control/status word and a fixed implementation/revision word. Software sees the status word through several 32-bit windows, each selected by a 5-bit register number. One window is the full word. One packs the eight condition codes into a contiguous byte. One holds only the cause and sticky-flag fields. One holds the trap enables, the rounding mode and the flush-to-zero control. Reads are combinational and are sign-extended to 64 bits. Writes take effect at the next rising clock edge.

The arithmetic side reports the events of each finished operation through a valid/ready update channel. `upd_ready` is tied high, so the channel never applies back-pressure and every cycle with `upd_valid` high is one accepted update. Comparison results reach single condition-code bits through a separate narrow port. After every control write to the cause, enable or full-word window, and after every update, the block evaluates whether a floating-point trap is due. It reports a due trap on `exc_req` as a one-cycle pulse, one cycle after the edge that caused it.

When several sources act in the same cycle, they apply in a fixed order: the update first, then the register write, then the single-bit condition-code write.

Top module: `fpu_ctrl_regs`

## Requirements
- R1: Synchronous active-high reset clears the status word to zero and drops `exc_req`.
- R2: Status word layout: rounding mode [1:0], sticky flags [6:2], enables [11:7], cause [17:12], reserved [22:18] always zero, condition code 0 at bit 23, flush-to-zero at bit 24, condition codes 1..7 at bits 25..31. Register number 31 reads the whole word. A write to 31 loads every bit except the reserved ones.
- R3: Register number 25 reads condition codes 0..7 packed into bits 7:0. A write to 25 spreads bits 7:0 back into the gapped positions and changes no other bit.
- R4: Register number 26 reads and writes only the cause and flag fields, in their native positions.
- R5: Register number 28 reads the enables and rounding mode in their native positions, with flush-to-zero shown at bit 2. A write to 28 takes flush-to-zero from bit 2, loads the enables and rounding mode, and keeps the condition codes, cause and flags.
- R6: Register number 0 reads the IMPL_REV parameter. Every number other than 0, 25, 26, 28 and 31 reads zero, and writes to those numbers change nothing.
- R7: `rd_data` is the selected 32-bit view sign-extended from bit 31 to 64 bits.
- R8: One cycle after a write to 26, 28 or 31, `exc_req` is high exactly when (cause AND enables) is nonzero or the unimplemented cause bit [17] is set. The check uses the state after the write.
- R9: An accepted update replaces the whole cause field with `upd_events`, using the bit order inexact=0, underflow=1, overflow=2, divide-by-zero=3, invalid=4, unimplemented=5. It ORs bits 4:0 into the sticky flags, never bit 5. It raises `exc_req` on the next cycle under the rule of R8.
- R10: A condition-code write sets bit `cc_pos(n)` (23 when n=0, else 24+n) to `cc_wr_val`. It is ignored when a write to 25 or 31 happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 5 | Register number for the read port |
| rd_data | output | 64 | Sign-extended read view |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register number for the write port |
| wr_data | input | 32 | Register write value |
| cc_wr_en | input | 1 | Single condition-code write strobe |
| cc_wr_idx | input | 3 | Condition-code number |
| cc_wr_val | input | 1 | Condition-code value |
| upd_valid | input | 1 | Arithmetic status update offered |
| upd_ready | output | 1 | Always high; no back-pressure |
| upd_events | input | 6 | Events of the finished operation |
| exc_req | output | 1 | Trap request pulse |

## Verification
The assertions assume that reset is held for at least one edge before use, and that checks on sticky flags and trap pulses hold only in cycles whose triggering sources are known. They take no inputs as constrained beyond being driven to 0 or 1. The bench drives every input on the falling edge and keeps all strobes low except the ones a step exercises. Conflicts between sources are therefore created only on purpose, as in the condition-code priority test, and the ordering rules stay observable through the read port.

// File: rtl/fpu_ctrl_pkg.sv
package fpu_ctrl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned CC_N    = 8;
  localparam int unsigned CC_IDX_W = $clog2(CC_N);
  localparam int unsigned EV_W    = 6;

  localparam logic [IDX_W-1:0] RN_IMPL = 5'd0;
  localparam logic [IDX_W-1:0] RN_CC   = 5'd25;
  localparam logic [IDX_W-1:0] RN_EXC  = 5'd26;
  localparam logic [IDX_W-1:0] RN_ENA  = 5'd28;
  localparam logic [IDX_W-1:0] RN_FULL = 5'd31;

  localparam logic [WORD_W-1:0] M_CC    = 32'hFE80_0000;
  localparam logic [WORD_W-1:0] M_FTZ   = 32'h0100_0000;
  localparam logic [WORD_W-1:0] M_RSVD  = 32'h007C_0000;
  localparam logic [WORD_W-1:0] M_CAUSE = 32'h0003_F000;
  localparam logic [WORD_W-1:0] M_ENA   = 32'h0000_0F80;
  localparam logic [WORD_W-1:0] M_FLAG  = 32'h0000_007C;
  localparam logic [WORD_W-1:0] M_RM    = 32'h0000_0003;

  localparam int unsigned CAUSE_LSB = 12;
  localparam int unsigned ENA_LSB   = 7;
  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned UNIMP_POS = CAUSE_LSB + 5;

  typedef logic [WORD_W-1:0] sword_t;

  function automatic logic [4:0] cc_pos(input logic [CC_IDX_W-1:0] n);
    return (n == '0) ? 5'd23 : (5'd24 + {2'b00, n});
  endfunction

  function automatic logic trap_due(input sword_t w);
    return ((w[CAUSE_LSB +: 5] & w[ENA_LSB +: 5]) != 5'd0) || w[UNIMP_POS];
  endfunction
endpackage

// File: rtl/fcr_event_merge.sv
module fcr_event_merge
  import fpu_ctrl_pkg::*;
(
  input  sword_t                cur_sw,
  input  logic                  fire,
  input  logic [EV_W-1:0]       events,
  output sword_t                nxt_sw
);
  sword_t cause_bits;
  sword_t flag_bits;

  always_comb begin
    cause_bits = sword_t'(events) << CAUSE_LSB;
    flag_bits  = sword_t'(events[4:0]) << FLAG_LSB;
    if (fire) nxt_sw = (cur_sw & ~M_CAUSE) | cause_bits | flag_bits;
    else      nxt_sw = cur_sw;
  end
endmodule

// File: rtl/fcr_write_merge.sv
module fcr_write_merge
  import fpu_ctrl_pkg::*;
(
  input  sword_t                cur_sw,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  sword_t                wr_data,
  output sword_t                nxt_sw,
  output logic                  trap_check,
  output logic                  cc_owned
);
  sword_t spread;
  sword_t ena_part;

  always_comb begin
    spread   = {wr_data[7:1], 1'b0, wr_data[0], 23'd0};
    ena_part = (wr_data & (M_ENA | M_RM)) | (wr_data[2] ? M_FTZ : '0);
    nxt_sw     = cur_sw;
    trap_check = 1'b0;
    cc_owned   = 1'b0;
    if (wr_en) begin
      unique case (wr_idx)
        RN_CC: begin
          nxt_sw   = (cur_sw & ~M_CC) | spread;
          cc_owned = 1'b1;
        end
        RN_EXC: begin
          nxt_sw     = (cur_sw & ~(M_CAUSE | M_FLAG)) | (wr_data & (M_CAUSE | M_FLAG));
          trap_check = 1'b1;
        end
        RN_ENA: begin
          nxt_sw     = (cur_sw & (M_CC | M_CAUSE | M_FLAG)) | ena_part;
          trap_check = 1'b1;
        end
        RN_FULL: begin
          nxt_sw     = wr_data & ~M_RSVD;
          trap_check = 1'b1;
          cc_owned   = 1'b1;
        end
        default: nxt_sw = cur_sw;
      endcase
    end
  end
endmodule

// File: rtl/fcr_read_view.sv
module fcr_read_view
  import fpu_ctrl_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL_REV = 32'h0000_0A31,
  parameter int unsigned       OUT_W    = 64
) (
  input  sword_t                sw,
  input  logic [IDX_W-1:0]      idx,
  output logic [OUT_W-1:0]      data
);
  localparam int unsigned EXT_W = OUT_W - WORD_W;
  sword_t view;

  always_comb begin
    unique case (idx)
      RN_IMPL: view = IMPL_REV;
      RN_CC:   view = {24'd0, sw[31:25], sw[23]};
      RN_EXC:  view = sw & (M_CAUSE | M_FLAG);
      RN_ENA:  view = (sw & (M_ENA | M_RM)) | {29'd0, sw[24], 2'b00};
      RN_FULL: view = sw & ~M_RSVD;
      default: view = '0;
    endcase
    data = {{EXT_W{view[WORD_W-1]}}, view};
  end
endmodule

// File: rtl/fpu_ctrl_regs.sv
module fpu_ctrl_regs
  import fpu_ctrl_pkg::*;
#(
  parameter logic [31:0] IMPL_REV = 32'h0000_0A31,
  parameter int unsigned OUT_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        rd_idx,
  output logic [OUT_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              cc_wr_en,
  input  logic [2:0]        cc_wr_idx,
  input  logic              cc_wr_val,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [5:0]        upd_events,
  output logic              exc_req
);
  sword_t sw_q, sw_ev, sw_wr, sw_d;
  logic   wr_trap, wr_cc_owned, upd_fire, trig;

  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid & upd_ready;

  fcr_event_merge u_ev (
    .cur_sw(sw_q), .fire(upd_fire), .events(upd_events), .nxt_sw(sw_ev)
  );

  fcr_write_merge u_wr (
    .cur_sw(sw_ev), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .nxt_sw(sw_wr), .trap_check(wr_trap), .cc_owned(wr_cc_owned)
  );

  always_comb begin
    sw_d = sw_wr;
    if (cc_wr_en && !wr_cc_owned) sw_d[cc_pos(cc_wr_idx)] = cc_wr_val;
  end

  assign trig = wr_trap | upd_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q    <= '0;
      exc_req <= 1'b0;
    end else begin
      sw_q    <= sw_d;
      exc_req <= trig && trap_due(sw_d);
    end
  end

  fcr_read_view #(.IMPL_REV(IMPL_REV), .OUT_W(OUT_W)) u_rd (
    .sw(sw_q), .idx(rd_idx), .data(rd_data)
  );

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sw_q[22:18] == 5'd0);

  // R8
  exc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(wr_en || upd_valid));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !wr_en) |=> ((sw_q[6:2] & $past(sw_q[6:2])) == $past(sw_q[6:2])));

  // R10
  cc_port_chk: assert property (@(posedge clk) disable iff (rst)
    (cc_wr_en && !wr_en) |=> (sw_q[cc_pos($past(cc_wr_idx))] == $past(cc_wr_val)));

  // R4
  exc_view_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 5'd26 && !upd_valid && !cc_wr_en) |=> $stable(sw_q[11:7]) && $stable(sw_q[1:0]));
endmodule

// File: tb/tb_fpu_ctrl_regs.sv
module tb_fpu_ctrl_regs;
  localparam logic [31:0] IMPL = 32'h0000_0A31;
  logic clk = 0;
  logic rst;
  logic [4:0] rd_idx, wr_idx;
  logic [63:0] rd_data;
  logic wr_en, cc_wr_en, cc_wr_val, upd_valid, upd_ready, exc_req;
  logic [31:0] wr_data;
  logic [2:0] cc_wr_idx;
  logic [5:0] upd_events;
  int errors = 0, checks = 0;
  logic [31:0] msw;
  logic mexc;

  always #4 clk = ~clk;

  fpu_ctrl_regs #(.IMPL_REV(IMPL)) dut (
    .clk, .rst, .rd_idx, .rd_data, .wr_en, .wr_idx, .wr_data,
    .cc_wr_en, .cc_wr_idx, .cc_wr_val, .upd_valid, .upd_ready,
    .upd_events, .exc_req
  );

  function automatic logic [31:0] m_view(input logic [31:0] w, input int n);
    case (n)
      0:  return IMPL;
      25: return {24'd0, w[31:25], w[23]};
      26: return w & 32'h0003_F07C;
      28: return (w & 32'h0000_0F83) | (w[24] ? 32'h4 : 32'h0);
      31: return w & 32'hFF83_FFFF;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_trap(input logic [31:0] w);
    return ((w[16:12] & w[11:7]) != 0) || w[17];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input int n);
    logic [31:0] v;
    v = m_view(msw, n);
    rd_idx = 5'(n);
    #1;
    chk(req, rd_data, {{32{v[31]}}, v});
  endtask

  task automatic do_write(input int n, input logic [31:0] v);
    wr_en = 1; wr_idx = 5'(n); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    mexc = 0;
    case (n)
      25: msw = (msw & 32'h017F_FFFF) | {v[7:1], 1'b0, v[0], 23'd0};
      26: begin msw = (msw & ~32'h0003_F07C) | (v & 32'h0003_F07C); mexc = m_trap(msw); end
      28: begin msw = (msw & 32'hFE83_F07C) | (v & 32'h0000_0F83) | (v[2] ? 32'h0100_0000 : 0); mexc = m_trap(msw); end
      31: begin msw = v & 32'hFF83_FFFF; mexc = m_trap(msw); end
      default: ;
    endcase
  endtask

  initial begin
    #(8*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; cc_wr_en = 0; upd_valid = 0; rd_idx = 0;
    wr_idx = 0; wr_data = 0; cc_wr_idx = 0; cc_wr_val = 0; upd_events = 0;
    msw = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    read_chk("R1", 31);
    chk("R1 exc", exc_req, 0);
    chk("R1 ready", upd_ready, 1);

    // R2 R6 R7 R3 R5 R4: full-word writes, sweep every read view
    for (int p = 0; p < 8; p++) begin
      logic [31:0] v;
      v = 32'hFFFF_FFFF >> (p*4) ^ (32'h9E37_79B9 * p);
      do_write(31, v);
      chk("R8 full", exc_req, mexc);
      for (int n = 0; n < 32; n++) read_chk("R2/R3/R4/R5/R6/R7 view", n);
    end

    // R3 packed condition-code write
    for (int c = 0; c < 256; c += 37) begin
      do_write(25, 32'hFFFF_FF00 | c);
      read_chk("R3", 25);
      read_chk("R3 other", 31);
    end

    // R4 exception window write
    do_write(31, 32'h0000_0F83);
    do_write(26, 32'hFFFF_FFFF);
    chk("R8 w26", exc_req, mexc);
    read_chk("R4", 31);

    // R5 enable window, flush-to-zero via bit 2
    for (int k = 0; k < 4; k++) begin
      do_write(28, 32'h0000_0A81 ^ (k * 32'h0000_0FFE));
      chk("R8 w28", exc_req, mexc);
      read_chk("R5", 28);
      read_chk("R5 full", 31);
    end

    // R6 writes to unlisted numbers ignored
    do_write(31, 32'h1234_5678);
    do_write(7, 32'hFFFF_FFFF);
    read_chk("R6 ignore", 31);

    // R9 update sweep over all event codes with two enable settings
    for (int e = 0; e < 2; e++) begin
      do_write(31, e ? 32'h0000_0A80 : 32'h0000_0000);
      for (int ev = 0; ev < 64; ev++) begin
        upd_valid = 1; upd_events = 6'(ev);
        @(negedge clk);
        upd_valid = 0;
        msw = (msw & ~32'h0003_F000) | (32'(ev) << 12) | (32'(ev & 31) << 2);
        chk("R9 exc", exc_req, m_trap(msw));
        read_chk("R9", 26);
      end
    end

    // R10 single-bit condition-code port
    do_write(31, 0);
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 2; b++) begin
        cc_wr_en = 1; cc_wr_idx = 3'(c); cc_wr_val = b[0];
        @(negedge clk);
        cc_wr_en = 0;
        msw[(c == 0) ? 23 : 24 + c] = b[0];
        read_chk("R10", 25);
      end
    end
    // R10 priority: full write wins over cc port
    cc_wr_en = 1; cc_wr_idx = 3'd3; cc_wr_val = 1;
    do_write(31, 32'h0000_0001);
    cc_wr_en = 0;
    read_chk("R10 prio", 31);
    chk("R8 no trap", exc_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule